// File: doc/BRIEF.md
# Indirect Switch Register Access Engine

This block gives a requester access to a large space of switch registers, selected by a 5-bit device/port number and a 5-bit register number. It does this through just two directly addressable registers behind one management address. Offset 0 holds a command word and offset 1 holds a data word. The block reaches both through an abstract register port: it raises a request, holds it, and waits for a one-cycle done or error pulse from a lower-level management engine. It never drives the serial management wires itself.

For each request the engine first waits until the switch is idle. It does this by reading the command register until its busy bit is clear. It then carries out the access order the switch expects:
- For a read, it writes the command, waits for idle again, and then reads the data register.
- For a write, it loads the data register, writes the command, and then waits for idle.

Every busy wait is bounded. If the wait runs out, the request ends with a timeout status. An error from the lower port ends the request at once. Only one request is in flight at any time.

Top module: `swreg_indirect_eng`

## Requirements
- R1: After reset, `req_ready` is 1 and `mp_req`, `rsp_done` and `rsp_err` are all 0.
- R2: Every write to offset 0 carries a command word with these fields:
  - bit 15 set;
  - bits 14:13 clear;
  - bit 12 set;
  - bits 11:10 equal to 2'b10 for a read or 2'b01 for a write;
  - bits 9:5 equal to the device/port number;
  - bits 4:0 equal to the register number.
- R3: The first accesses of every request are reads of offset 0. They repeat until a read returns bit 15 clear. No other access comes before that read.
- R4: A read request issues these accesses in order: the idle wait, the command write, a second idle wait, and then one read of offset 1. The data of that last read appears on `rsp_rdata` together with `rsp_done`.
- R5: A write request issues these accesses in order: the idle wait, a write of the request data to offset 1, the command write, and a final idle wait. Only after that wait does the engine signal completion.
- R6: Each idle wait allows at most POLL_LIMIT reads of offset 0. If all POLL_LIMIT reads return busy, the request ends with `rsp_err` and `rsp_status` = 2'b01. No further access is issued. A wait that ends on read number POLL_LIMIT succeeds.
- R7: An `mp_err` pulse ends the request at once. The engine then pulses `rsp_err` with `rsp_status` = 2'b10, and issues no further access.
- R8: `req_ready` falls after a request is accepted. It stays low until the cycle after the completion pulse. A `req_valid` that arrives while `req_ready` is low has no effect.
- R9: Completion is a pulse exactly one cycle long on `rsp_done` (with `rsp_status` = 2'b00) or on `rsp_err`, never both. In the next cycle `req_ready` is 1 again.
- R10: Once raised, `mp_req`, `mp_write`, `mp_addr` and `mp_wdata` stay stable until the lower port answers with `mp_done` or `mp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device/port number |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Data word for writes |
| rsp_done | output | 1 | One-cycle success pulse |
| rsp_err | output | 1 | One-cycle failure pulse |
| rsp_status | output | 2 | 00 ok, 01 busy timeout, 10 lower port error |
| rsp_rdata | output | 16 | Data returned by the last read request |
| mp_req | output | 1 | Lower port access request, held until answered |
| mp_write | output | 1 | Lower port access is a write |
| mp_addr | output | 5 | Register offset at the management address |
| mp_wdata | output | 16 | Lower port write data |
| mp_done | input | 1 | Lower port access completed (one cycle) |
| mp_err | input | 1 | Lower port access failed (one cycle) |
| mp_rdata | input | 16 | Lower port read data, valid with mp_done |

## Verification
A sequencer in the wrong state shows up at the lower port on the very next access. The bench logs each access and compares the whole trace with one predicted from the request. A wrong trace can be a missing idle wait, a data load in the wrong place, or a malformed command word. A poll counter that is off by one changes the access count in the boundary cases: busy for POLL_LIMIT-1 reads, which must succeed, and busy for POLL_LIMIT reads, which must time out. A stuck status or capture register shows up as a wrong status code or stale read data in the completion cycle. A broken command word also corrupts the switch model's register image, and a later read-back exposes that.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam int DATA_W = 16;
    localparam int FLD_W  = 5;
    localparam int OFS_W  = 5;

    localparam logic [OFS_W-1:0] OFS_CMD  = OFS_W'(0);
    localparam logic [OFS_W-1:0] OFS_DATA = OFS_W'(1);

    localparam int BUSY_BIT = 15;
    localparam int MARK_BIT = 12;
    localparam int OP_LSB   = 10;
    localparam int DEV_LSB  = 5;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } op_e;

    typedef enum logic [1:0] {
        RSP_OK       = 2'b00,
        RSP_TIMEOUT  = 2'b01,
        RSP_PORT_ERR = 2'b10
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_POLL,
        ST_DATA_WR,
        ST_CMD_WR,
        ST_POST_POLL,
        ST_DATA_RD,
        ST_RESP
    } seq_e;

    typedef struct packed {
        logic              is_wr;
        logic [FLD_W-1:0]  dev;
        logic [FLD_W-1:0]  regn;
        logic [DATA_W-1:0] wdata;
    } xreq_t;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] wdata;
    } acc_t;

    function automatic logic [DATA_W-1:0] build_cmd(input xreq_t r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BUSY_BIT] = 1'b1;
        w[MARK_BIT] = 1'b1;
        w[OP_LSB +: 2] = r.is_wr ? OP_WR : OP_RD;
        w[DEV_LSB +: FLD_W] = r.dev;
        w[0 +: FLD_W] = r.regn;
        return w;
    endfunction

    function automatic logic is_poll(input seq_e s);
        return (s == ST_PRE_POLL) || (s == ST_POST_POLL);
    endfunction

endpackage

// File: rtl/swreg_poll_cnt.sv
module swreg_poll_cnt #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/swreg_port_drv.sv
module swreg_port_drv
    import swreg_pkg::*;
(
    input  seq_e  state,
    input  xreq_t xreq,
    output acc_t  acc
);
    always_comb begin
        acc = '0;
        unique case (state)
            ST_PRE_POLL, ST_POST_POLL: begin
                acc.req = 1'b1;
                acc.ofs = OFS_CMD;
            end
            ST_DATA_WR: begin
                acc.req   = 1'b1;
                acc.wr    = 1'b1;
                acc.ofs   = OFS_DATA;
                acc.wdata = xreq.wdata;
            end
            ST_CMD_WR: begin
                acc.req   = 1'b1;
                acc.wr    = 1'b1;
                acc.ofs   = OFS_CMD;
                acc.wdata = build_cmd(xreq);
            end
            ST_DATA_RD: begin
                acc.req = 1'b1;
                acc.ofs = OFS_DATA;
            end
            default: acc = '0;
        endcase
    end
endmodule

// File: rtl/swreg_seq_fsm.sv
module swreg_seq_fsm
    import swreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_wr,
    input  logic              acc_done,
    input  logic              acc_err,
    input  logic [DATA_W-1:0] acc_rdata,
    input  logic              poll_last,
    output seq_e              state,
    output rsp_e              status,
    output logic [DATA_W-1:0] rdata,
    output logic              poll_clr,
    output logic              poll_inc
);
    seq_e state_n;
    rsp_e status_n;
    logic rd_cap;
    logic in_access;

    assign in_access = (state != ST_IDLE) && (state != ST_RESP);
    assign poll_clr  = !is_poll(state);

    always_comb begin
        state_n  = state;
        status_n = status;
        rd_cap   = 1'b0;
        poll_inc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n  = ST_PRE_POLL;
                    status_n = RSP_OK;
                end
            end
            ST_PRE_POLL, ST_POST_POLL: begin
                if (acc_done) begin
                    if (acc_rdata[BUSY_BIT]) begin
                        if (poll_last) begin
                            state_n  = ST_RESP;
                            status_n = RSP_TIMEOUT;
                        end else begin
                            poll_inc = 1'b1;
                        end
                    end else if (state == ST_PRE_POLL) begin
                        state_n = is_wr ? ST_DATA_WR : ST_CMD_WR;
                    end else if (is_wr) begin
                        state_n  = ST_RESP;
                        status_n = RSP_OK;
                    end else begin
                        state_n = ST_DATA_RD;
                    end
                end
            end
            ST_DATA_WR: if (acc_done) state_n = ST_CMD_WR;
            ST_CMD_WR:  if (acc_done) state_n = ST_POST_POLL;
            ST_DATA_RD: begin
                if (acc_done) begin
                    state_n  = ST_RESP;
                    status_n = RSP_OK;
                    rd_cap   = 1'b1;
                end
            end
            ST_RESP: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (in_access && acc_err) begin
            state_n  = ST_RESP;
            status_n = RSP_PORT_ERR;
            rd_cap   = 1'b0;
            poll_inc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            status <= RSP_OK;
            rdata  <= '0;
        end else begin
            state  <= state_n;
            status <= status_n;
            if (rd_cap) rdata <= acc_rdata;
        end
    end
endmodule

// File: rtl/swreg_indirect_eng.sv
module swreg_indirect_eng
    import swreg_pkg::*;
#(
    parameter int POLL_LIMIT = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [FLD_W-1:0]  req_dev,
    input  logic [FLD_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mp_req,
    output logic              mp_write,
    output logic [OFS_W-1:0]  mp_addr,
    output logic [DATA_W-1:0] mp_wdata,
    input  logic              mp_done,
    input  logic              mp_err,
    input  logic [DATA_W-1:0] mp_rdata
);
    xreq_t xreq_q;
    seq_e  state;
    rsp_e  status;
    acc_t  acc;
    logic  start;
    logic  poll_clr;
    logic  poll_inc;
    logic  poll_last;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            xreq_q <= '0;
        end else if (start) begin
            xreq_q <= '{is_wr: req_write, dev: req_dev, regn: req_reg, wdata: req_wdata};
        end
    end

    swreg_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_wr     (xreq_q.is_wr),
        .acc_done  (mp_done),
        .acc_err   (mp_err),
        .acc_rdata (mp_rdata),
        .poll_last (poll_last),
        .state     (state),
        .status    (status),
        .rdata     (rsp_rdata),
        .poll_clr  (poll_clr),
        .poll_inc  (poll_inc)
    );

    swreg_poll_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr),
        .inc  (poll_inc),
        .last (poll_last)
    );

    swreg_port_drv u_drv (
        .state (state),
        .xreq  (xreq_q),
        .acc   (acc)
    );

    assign mp_req     = acc.req;
    assign mp_write   = acc.wr;
    assign mp_addr    = acc.ofs;
    assign mp_wdata   = acc.wdata;
    assign rsp_done   = (state == ST_RESP) && (status == RSP_OK);
    assign rsp_err    = (state == ST_RESP) && (status != RSP_OK);
    assign rsp_status = status;
endmodule

// File: rtl/swreg_indirect_eng_chk.sv
module swreg_indirect_eng_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic [1:0]  rsp_status,
    input logic        mp_req,
    input logic        mp_write,
    input logic [4:0]  mp_addr,
    input logic [15:0] mp_wdata,
    input logic        mp_done,
    input logic        mp_err
);
    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !mp_req && !rsp_done && !rsp_err));

    // R2
    p_cmd_format_r2: assert property (@(posedge clk) disable iff (rst)
        (mp_req && mp_write && mp_addr == 5'd0) |->
            (mp_wdata[15] && mp_wdata[12] && mp_wdata[14:13] == 2'b00 &&
             (mp_wdata[11:10] == 2'b01 || mp_wdata[11:10] == 2'b10)));

    // R7
    p_abort_on_err_r7: assert property (@(posedge clk) disable iff (rst)
        mp_err |=> (!mp_req && rsp_err && rsp_status == 2'b10));

    // R8
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_no_access_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mp_req);

    // R9
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_done || rsp_err) |=> (!rsp_done && !rsp_err && req_ready));

    p_exclusive_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        !(rsp_done && rsp_err));

    // R10
    p_hold_access_r10: assert property (@(posedge clk) disable iff (rst)
        (mp_req && !mp_done && !mp_err) |=>
            (mp_req && $stable(mp_write) && $stable(mp_addr) && $stable(mp_wdata)));
endmodule

bind swreg_indirect_eng swreg_indirect_eng_chk u_chk (.*);

// File: tb/swreg_indirect_eng_test.sv
`timescale 1ns/1ps
module swreg_indirect_eng_test;
    localparam int LIM    = 100;
    localparam int LOGMAX = 256;

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  dev;
        logic [4:0]  rg;
        logic [15:0] wdata;
        logic [7:0]  pre;
        logic [7:0]  post;
        logic [7:0]  inj;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'd3,  5'd4,  16'hBEEF, 8'd0,   8'd0,   8'd0, 16'h0000},
        '{1'b0, 5'd3,  5'd4,  16'h0000, 8'd0,   8'd0,   8'd0, 16'hBEEF},
        '{1'b1, 5'd31, 5'd31, 16'h1234, 8'd2,   8'd3,   8'd0, 16'h0000},
        '{1'b0, 5'd31, 5'd31, 16'h0000, 8'd1,   8'd2,   8'd0, 16'h1234},
        '{1'b0, 5'd27, 5'd0,  16'h0000, 8'd0,   8'd5,   8'd0, 16'hA360},
        '{1'b1, 5'd5,  5'd9,  16'hCAFE, 8'd99,  8'd0,   8'd0, 16'h0000},
        '{1'b0, 5'd5,  5'd9,  16'h0000, 8'd0,   8'd99,  8'd0, 16'hCAFE},
        '{1'b0, 5'd1,  5'd1,  16'h0000, 8'd100, 8'd0,   8'd0, 16'h0000},
        '{1'b1, 5'd2,  5'd2,  16'h5555, 8'd0,   8'd100, 8'd0, 16'h0000},
        '{1'b0, 5'd2,  5'd2,  16'h0000, 8'd0,   8'd0,   8'd0, 16'h5555},
        '{1'b1, 5'd6,  5'd7,  16'h7777, 8'd0,   8'd0,   8'd2, 16'h0000},
        '{1'b0, 5'd6,  5'd7,  16'h0000, 8'd0,   8'd0,   8'd0, 16'hA0C7},
        '{1'b0, 5'd8,  5'd8,  16'h0000, 8'd0,   8'd0,   8'd3, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_rdata;
    logic        mp_req, mp_write;
    logic [4:0]  mp_addr;
    logic [15:0] mp_wdata;
    logic        mp_done = 1'b0;
    logic        mp_err = 1'b0;
    logic [15:0] mp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    swreg_indirect_eng uut (.*);

    // switch-side model
    logic [15:0] mem [1024];
    logic [15:0] cmd_reg = '0;
    logic [15:0] data_reg = '0;
    int busy_left = 0;
    int post_cfg = 0;
    int inj_at = 0;
    int acc_n = 0;
    logic        log_w [LOGMAX];
    logic [4:0]  log_a [LOGMAX];
    logic [15:0] log_d [LOGMAX];

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'hA000 ^ 16'(i);
    end

    always @(negedge clk) begin
        if (rst) begin
            mp_done = 1'b0;
            mp_err  = 1'b0;
        end else if (mp_done || mp_err) begin
            mp_done = 1'b0;
            mp_err  = 1'b0;
        end else if (mp_req) begin
            if (acc_n < LOGMAX) begin
                log_w[acc_n] = mp_write;
                log_a[acc_n] = mp_addr;
                log_d[acc_n] = mp_wdata;
            end
            acc_n = acc_n + 1;
            if (inj_at != 0 && acc_n == inj_at) begin
                mp_err = 1'b1;
            end else begin
                mp_done = 1'b1;
                if (mp_addr == 5'd0 && !mp_write) begin
                    if (busy_left > 0) begin
                        mp_rdata  = 16'h8000 | cmd_reg;
                        busy_left = busy_left - 1;
                    end else begin
                        mp_rdata = cmd_reg & 16'h7FFF;
                    end
                end else if (mp_addr == 5'd0) begin
                    cmd_reg   = mp_wdata;
                    busy_left = post_cfg;
                    if (mp_wdata[11:10] == 2'b10) data_reg = mem[mp_wdata[9:0]];
                    else if (mp_wdata[11:10] == 2'b01) mem[mp_wdata[9:0]] = data_reg;
                end else if (mp_addr == 5'd1 && mp_write) begin
                    data_reg = mp_wdata;
                end else begin
                    mp_rdata = data_reg;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected access trace
    logic        ex_w [LOGMAX];
    logic [4:0]  ex_a [LOGMAX];
    logic [15:0] ex_d [LOGMAX];
    int ex_n;
    logic [1:0] ex_st;

    task automatic push(input logic w, input logic [4:0] a, input logic [15:0] d);
        ex_w[ex_n] = w; ex_a[ex_n] = a; ex_d[ex_n] = d;
        ex_n++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [15:0] cmd;
        bit to;
        cmd = {1'b1, 2'b00, 1'b1, (v.is_wr ? 2'b01 : 2'b10), v.dev, v.rg};
        ex_n = 0;
        to = 0;
        for (int i = 0; i < ((v.pre >= LIM) ? LIM : v.pre + 1); i++) push(1'b0, 5'd0, 16'h0);
        if (v.pre >= LIM) to = 1;
        if (!to) begin
            if (v.is_wr) push(1'b1, 5'd1, v.wdata);
            push(1'b1, 5'd0, cmd);
            for (int i = 0; i < ((v.post >= LIM) ? LIM : v.post + 1); i++) push(1'b0, 5'd0, 16'h0);
            if (v.post >= LIM) to = 1;
            else if (!v.is_wr) push(1'b0, 5'd1, 16'h0);
        end
        ex_st = to ? 2'b01 : 2'b00;
        if (v.inj != 0 && int'(v.inj) <= ex_n) begin
            ex_n  = int'(v.inj);
            ex_st = 2'b10;
        end
    endtask

    task automatic run(input vec_t v, input string tag);
        int wait_n;
        bit trace_ok;
        logic [1:0] st;
        logic ok_pulse;
        build_exp(v);
        @(negedge clk);
        busy_left = int'(v.pre);
        post_cfg  = int'(v.post);
        inj_at    = int'(v.inj);
        acc_n     = 0;
        req_valid = 1'b1;
        req_write = v.is_wr;
        req_dev   = v.dev;
        req_reg   = v.rg;
        req_wdata = v.wdata;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 0;
        while (!(rsp_done || rsp_err) && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        st = rsp_status;
        ok_pulse = rsp_done;
        // R6 R7 R9: status code and which pulse
        check(st == ex_st && ok_pulse == (ex_st == 2'b00), {tag, " R9 R6 R7"}, "status",
              {29'd0, ok_pulse, st}, {29'd0, (ex_st == 2'b00), ex_st});
        if (!v.is_wr && ex_st == 2'b00)
            check(rsp_rdata == v.exp_rd, {tag, " R4"}, "read data", rsp_rdata, v.exp_rd);
        @(negedge clk);
        check(!rsp_done && !rsp_err && req_ready, {tag, " R9"}, "pulse width/ready",
              {29'd0, rsp_done, rsp_err, req_ready}, 32'h1);
        check(acc_n == ex_n, {tag, " R3 R6 R7"}, "access count", acc_n, ex_n);
        trace_ok = 1;
        for (int i = 0; i < ex_n && i < acc_n && i < LOGMAX; i++) begin
            if (trace_ok && (log_w[i] != ex_w[i] || log_a[i] != ex_a[i] ||
                             (ex_w[i] && log_d[i] != ex_d[i]))) begin
                trace_ok = 0;
                check(0, {tag, " R2 R4 R5"}, $sformatf("access %0d", i),
                      {log_w[i], 10'd0, log_a[i], log_d[i]}, {ex_w[i], 10'd0, ex_a[i], ex_d[i]});
            end
        end
        if (trace_ok) check(1, {tag, " R2 R4 R5"}, "trace", 0, 0);
        inj_at = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && !mp_req && !rsp_done && !rsp_err, "R1", "reset outputs",
              {28'd0, req_ready, mp_req, rsp_done, rsp_err}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mp_req, "R1", "idle after reset", {30'd0, req_ready, mp_req}, 32'h2);

        for (int k = 0; k < NV; k++) run(TBL[k], $sformatf("vec%0d", k));

        // R8: request arriving while busy is ignored
        begin
            bit low_ok;
            int wait_n;
            @(negedge clk);
            busy_left = 0; post_cfg = 5; acc_n = 0;
            req_valid = 1'b1; req_write = 1'b0; req_dev = 5'd3; req_reg = 5'd4; req_wdata = 16'h0;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_write = 1'b1; req_dev = 5'd9; req_reg = 5'd9; req_wdata = 16'h9999;
            low_ok = 1; wait_n = 0;
            while (!(rsp_done || rsp_err) && wait_n < 5000) begin
                if (req_ready) low_ok = 0;
                @(negedge clk);
                wait_n++;
            end
            req_valid = 1'b0;
            check(low_ok, "R8", "ready low while busy", {31'd0, low_ok}, 32'd1);
            check(rsp_done && rsp_rdata == 16'hBEEF, "R8", "first request result",
                  rsp_rdata, 16'hBEEF);
            @(negedge clk);
            @(negedge clk);
            check(acc_n == 9, "R8", "no extra access from held valid", acc_n, 9);
        end
        run('{1'b0, 5'd9, 5'd9, 16'h0, 8'd0, 8'd0, 8'd0, 16'hA129}, "ignored-write R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule